// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block keeps a CAN controller in one of three operating modes: sleep, initialization or normal. Software writes a small control word holding an init request, a sleep request and an automatic wake-up enable. The sequencer answers with two acknowledge flags, one for init and one for sleep. An acknowledge changes only once the move to the new mode has actually completed. Entering normal mode requires the receiver to see an idle bus first. Leaving normal mode waits until the protocol engine reports that it is idle.

The bit-level engine lies outside the block. It is represented by four inputs: an idle indicator, a start-of-frame strobe, a per-bit sample strobe and the sampled recessive level. The block also holds the bit-timing and mode configuration word and drives it to the engine. Software can change that word only while the init acknowledge is set. A sleeping controller can be woken by an incoming frame when automatic wake-up is enabled. Such a wake-up raises a one-cycle interrupt. A wake-up requested by software raises none.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, sleep_ack_o is 1, init_ack_o is 0, wake_irq_o is 0, every configuration output is 0 and automatic wake-up is disabled. A start-of-frame seen while in this state leaves the block asleep and raises no interrupt.
- R2: With the init request set, the block enters init (init_ack_o=1, sleep_ack_o=0) whatever the sleep request is. From sleep this happens immediately; from normal mode the bus-idle rule of R5 applies. The acknowledge follows the control write by two clock edges.
- R3: With the init request clear and the sleep request set, the block enters sleep (sleep_ack_o=1, init_ack_o=0).
- R4: With both requests clear, the block enters normal mode (both acknowledges 0) only on the sampled bit that completes 11 consecutive recessive bits (bit_tick_i with rx_recessive_i=1). A dominant sample restarts the count. The previous acknowledge flags are held until then.
- R5: A move out of normal mode into init or sleep takes place only on a clock edge where bus_idle_i is 1.
- R6: init_ack_o and sleep_ack_o are never 1 together.
- R7: A cfg_we_i write is accepted only while init_ack_o is 1; otherwise the outputs keep their value. The word layout from bit 0 upward is: prescaler-1 [9:0] on presc_o, first segment-1 [13:10] on seg1_o, second segment-1 [16:14] on seg2_o, sync-jump width-1 [18:17] on sjw_o, silent [19], loopback [20] and single-shot (no retransmit) [21].
- R8: With automatic wake-up enabled, a sof_i pulse while asleep (and the init request clear) does three things. It clears the sleep request. It raises wake_irq_o for exactly one cycle, one edge later, while sleep_ack_o is still 1. The block then follows R4 into normal mode.
- R9: Clearing the sleep request by a control write never raises wake_irq_o. sof_i while asleep has no effect when automatic wake-up is disabled.
- R10: The control word is init request [0], sleep request [1] and automatic wake-up enable [2]. If a control write falls in the same cycle as a bus wake-up, the written value is stored and wake_irq_o is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 3 | Control word: init req, sleep req, auto wake enable |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 22 | Configuration word (layout in R7) |
| bus_idle_i | input | 1 | Protocol engine has no frame in progress |
| sof_i | input | 1 | Start-of-frame detected on the bus |
| bit_tick_i | input | 1 | One bit sampled on RX this cycle |
| rx_recessive_i | input | 1 | Sampled bit is recessive |
| init_ack_o | output | 1 | Init mode acknowledged |
| sleep_ack_o | output | 1 | Sleep mode acknowledged |
| wake_irq_o | output | 1 | One-cycle wake-up interrupt from bus activity |
| presc_o | output | 10 | Prescaler minus one |
| seg1_o | output | 4 | First time segment minus one |
| seg2_o | output | 3 | Second time segment minus one |
| sjw_o | output | 2 | Sync-jump width minus one |
| silent_o | output | 1 | Silent mode: transmitter cut from the pin |
| loopback_o | output | 1 | Loopback: transmitter tied to receiver internally |
| one_shot_o | output | 1 | Each frame is tried only once |

## Verification
A control write and a bus wake-up can hit the sleep request in the same cycle. The bench provokes this by pulsing sof_i while asleep with wake-up enabled, in the very cycle a control write clears the sleep request. It then checks two things: the interrupt still fires once, and the block settles in normal mode after 11 recessive bits. A second overlap is an init request raised in normal mode while the bus is busy. The bench holds bus_idle_i low and confirms that the init acknowledge arrives only on the edge after the idle indicator rises.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    M_SLEEP  = 2'd0,
    M_INIT   = 2'd1,
    M_SYNC   = 2'd2,
    M_NORMAL = 2'd3
  } mode_e;

  localparam int CTL_W         = 3;
  localparam int CTL_INIT_BIT  = 0;
  localparam int CTL_SLEEP_BIT = 1;
  localparam int CTL_WAKE_BIT  = 2;
endpackage

// File: rtl/can_mode_ctl_reg.sv
module can_mode_ctl_reg
  import can_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  mode_e            mode_i,
  input  logic             sof_i,
  output logic             init_req_o,
  output logic             sleep_req_o,
  output logic             wake_irq_o
);
  logic init_req_q, sleep_req_q, wake_en_q, irq_q;
  logic wake_hit;

  // bus wake only from a settled sleep with sleep still requested
  assign wake_hit = (mode_i == M_SLEEP) && sleep_req_q && !init_req_q &&
                    wake_en_q && sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_req_q  <= 1'b0;
      sleep_req_q <= 1'b1;
      wake_en_q   <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= wake_hit;
      if (we_i) begin
        init_req_q  <= wdata_i[CTL_INIT_BIT];
        sleep_req_q <= wdata_i[CTL_SLEEP_BIT];
        wake_en_q   <= wdata_i[CTL_WAKE_BIT];
      end else if (wake_hit) begin
        sleep_req_q <= 1'b0;
      end
    end
  end

  assign init_req_o  = init_req_q;
  assign sleep_req_o = sleep_req_q;
  assign wake_irq_o  = irq_q;
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  init_req_i,
  input  logic  sleep_req_i,
  input  logic  bus_idle_i,
  input  logic  bit_tick_i,
  input  logic  rx_recessive_i,
  output mode_e mode_o,
  output logic  init_ack_o,
  output logic  sleep_ack_o
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  mode_e            mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q;
  logic             sync_done;
  logic             init_ack_q, sleep_ack_q;

  assign sync_done = bit_tick_i && rx_recessive_i && (cnt_q == LAST);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_SLEEP: begin
        if (init_req_i)        mode_d = M_INIT;
        else if (!sleep_req_i) mode_d = M_SYNC;
      end
      M_INIT: begin
        if (!init_req_i) mode_d = sleep_req_i ? M_SLEEP : M_SYNC;
      end
      M_SYNC: begin
        if (init_req_i)       mode_d = M_INIT;
        else if (sleep_req_i) mode_d = M_SLEEP;
        else if (sync_done)   mode_d = M_NORMAL;
      end
      M_NORMAL: begin
        if ((init_req_i || sleep_req_i) && bus_idle_i)
          mode_d = init_req_i ? M_INIT : M_SLEEP;
      end
      default: mode_d = M_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_SLEEP;
      cnt_q       <= '0;
      init_ack_q  <= 1'b0;
      sleep_ack_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
      if (mode_q != M_SYNC) cnt_q <= '0;
      else if (bit_tick_i) cnt_q <= !rx_recessive_i ? '0 :
                                    (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
      // acknowledges move only when a transition completes
      if (mode_d != M_SYNC) begin
        init_ack_q  <= (mode_d == M_INIT);
        sleep_ack_q <= (mode_d == M_SLEEP);
      end
    end
  end

  assign mode_o      = mode_q;
  assign init_ack_o  = init_ack_q;
  assign sleep_ack_o = sleep_ack_q;
endmodule

// File: rtl/can_mode_cfg_reg.sv
module can_mode_cfg_reg #(
  parameter int CFG_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             unlock_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_q <= '0;
    else if (we_i && unlock_i)  cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int PRESC_W   = 10,
  parameter int SEG1_W    = 4,
  parameter int SEG2_W    = 3,
  parameter int SJW_W     = 2,
  parameter int IDLE_BITS = 11,
  localparam int CfgW     = PRESC_W + SEG1_W + SEG2_W + SJW_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_we_i,
  input  logic [CTL_W-1:0]   ctl_wdata_i,
  input  logic               cfg_we_i,
  input  logic [CfgW-1:0]    cfg_wdata_i,
  input  logic               bus_idle_i,
  input  logic               sof_i,
  input  logic               bit_tick_i,
  input  logic               rx_recessive_i,
  output logic               init_ack_o,
  output logic               sleep_ack_o,
  output logic               wake_irq_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [SEG1_W-1:0]  seg1_o,
  output logic [SEG2_W-1:0]  seg2_o,
  output logic [SJW_W-1:0]   sjw_o,
  output logic               silent_o,
  output logic               loopback_o,
  output logic               one_shot_o
);
  localparam int SEG1_LO = PRESC_W;
  localparam int SEG2_LO = SEG1_LO + SEG1_W;
  localparam int SJW_LO  = SEG2_LO + SEG2_W;
  localparam int FLAG_LO = SJW_LO + SJW_W;

  mode_e           mode;
  logic            init_req, sleep_req;
  logic [CfgW-1:0] cfg_word;

  can_mode_ctl_reg u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctl_we_i),
    .wdata_i     (ctl_wdata_i),
    .mode_i      (mode),
    .sof_i       (sof_i),
    .init_req_o  (init_req),
    .sleep_req_o (sleep_req),
    .wake_irq_o  (wake_irq_o)
  );

  can_mode_fsm #(.IDLE_BITS(IDLE_BITS)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .init_req_i     (init_req),
    .sleep_req_i    (sleep_req),
    .bus_idle_i     (bus_idle_i),
    .bit_tick_i     (bit_tick_i),
    .rx_recessive_i (rx_recessive_i),
    .mode_o         (mode),
    .init_ack_o     (init_ack_o),
    .sleep_ack_o    (sleep_ack_o)
  );

  can_mode_cfg_reg #(.CFG_W(CfgW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .unlock_i (init_ack_o),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (cfg_word)
  );

  assign presc_o    = cfg_word[PRESC_W-1:0];
  assign seg1_o     = cfg_word[SEG1_LO +: SEG1_W];
  assign seg2_o     = cfg_word[SEG2_LO +: SEG2_W];
  assign sjw_o      = cfg_word[SJW_LO +: SJW_W];
  assign silent_o   = cfg_word[FLAG_LO];
  assign loopback_o = cfg_word[FLAG_LO+1];
  assign one_shot_o = cfg_word[FLAG_LO+2];
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk #(
  parameter int CFG_W = 22
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_ack_o,
  input logic             sleep_ack_o,
  input logic             wake_irq_o,
  input logic             bus_idle_i,
  input logic             bit_tick_i,
  input logic             rx_recessive_i,
  input logic [CFG_W-1:0] cfg_word
);
  assert_acks_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_ack_o && sleep_ack_o));

  assert_cfg_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_ack_o |=> $stable(cfg_word));

  assert_irq_while_asleep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> sleep_ack_o);

  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o);

  assert_normal_on_recessive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_ack_o && !sleep_ack_o && $past(init_ack_o || sleep_ack_o))
      |-> $past(bit_tick_i && rx_recessive_i));

  assert_leave_normal_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((init_ack_o || sleep_ack_o) && $past(!init_ack_o && !sleep_ack_o))
      |-> $past(bus_idle_i));
endmodule

bind can_mode_seq can_mode_chk #(.CFG_W(CfgW)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .init_ack_o     (init_ack_o),
  .sleep_ack_o    (sleep_ack_o),
  .wake_irq_o     (wake_irq_o),
  .bus_idle_i     (bus_idle_i),
  .bit_tick_i     (bit_tick_i),
  .rx_recessive_i (rx_recessive_i),
  .cfg_word       (cfg_word)
);

// File: tb/can_mode_seq_tb_top.sv
`timescale 1ns/1ps
module can_mode_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [21:0] cfg_wdata = '0;
  logic        bus_idle = 1'b1;
  logic        sof = 1'b0;
  logic        bit_tick = 1'b0;
  logic        rx_rec = 1'b1;
  logic        init_ack, sleep_ack, wake_irq;
  logic [9:0]  presc;
  logic [3:0]  seg1;
  logic [2:0]  seg2;
  logic [1:0]  sjw;
  logic        silent, loopback, one_shot;

  always #2.5 clk = ~clk;

  can_mode_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .bus_idle_i(bus_idle), .sof_i(sof),
    .bit_tick_i(bit_tick), .rx_recessive_i(rx_rec),
    .init_ack_o(init_ack), .sleep_ack_o(sleep_ack), .wake_irq_o(wake_irq),
    .presc_o(presc), .seg1_o(seg1), .seg2_o(seg2), .sjw_o(sjw),
    .silent_o(silent), .loopback_o(loopback), .one_shot_o(one_shot)
  );

  typedef enum int {K_INIT, K_SLEEP, K_IRQ, K_CFG} kind_e;
  typedef struct {
    string       tag;
    kind_e       kind;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // driver side: queue an expectation for the current sample point
  task automatic expect_val(input string tag, input kind_e kind, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic expect_modes(input string tag, input bit ei, input bit es);
    expect_val(tag, K_INIT, 32'(ei));
    expect_val(tag, K_SLEEP, 32'(es));
  endtask

  // monitor: pop and compare just after each falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_INIT:  act = 32'(init_ack);
        K_SLEEP: act = 32'(sleep_ack);
        K_IRQ:   act = 32'(wake_irq);
        default: act = 32'({one_shot, loopback, silent, sjw, seg2, seg1, presc});
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [2:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic cfg_write(input logic [21:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tick(input bit rec);
    @(negedge clk); bit_tick = 1'b1; rx_rec = rec;
    @(negedge clk); bit_tick = 1'b0; rx_rec = 1'b1;
  endtask

  task automatic ticks(input int n, input bit chk_irq);
    for (int i = 0; i < n; i++) begin
      tick(1'b1);
      if (chk_irq) expect_val("R9 no irq on software wake", K_IRQ, 32'd0);
    end
  endtask

  localparam logic [21:0] W1 = 22'h2A_5C3;
  localparam logic [21:0] W2 = 22'h15_5AA;

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_modes("R1 reset modes", 1'b0, 1'b1);
    expect_val("R1 reset irq", K_IRQ, 32'd0);
    expect_val("R1 reset cfg", K_CFG, 32'd0);

    // R1/R9: wake-up disabled after reset, sof ignored
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    expect_val("R9 sof with wake disabled", K_IRQ, 32'd0);
    step(3);
    expect_modes("R1 still asleep", 1'b0, 1'b1);

    cfg_write(W1);
    expect_val("R7 cfg write in sleep ignored", K_CFG, 32'd0);

    ctl_write(3'b001);
    step(1);
    expect_modes("R2 enter init", 1'b1, 1'b0);

    cfg_write(W1);
    expect_val("R7 cfg write in init", K_CFG, 32'(W1));

    ctl_write(3'b011);
    step(1);
    expect_modes("R2 init over sleep", 1'b1, 1'b0);

    ctl_write(3'b010);
    step(1);
    expect_modes("R3 init to sleep", 1'b0, 1'b1);

    // R4: leave sleep, dominant bit restarts the count
    ctl_write(3'b000);
    step(1);
    ticks(5, 1'b0);
    tick(1'b0);
    ticks(10, 1'b0);
    expect_modes("R4 ten recessive not enough", 1'b0, 1'b1);
    tick(1'b1);
    expect_modes("R4 normal after eleven", 1'b0, 1'b0);

    cfg_write(W2);
    expect_val("R7 cfg write in normal ignored", K_CFG, 32'(W1));

    // R5: init request waits for bus idle
    bus_idle = 1'b0;
    ctl_write(3'b001);
    step(3);
    expect_modes("R5 held while bus busy", 1'b0, 1'b0);
    bus_idle = 1'b1;
    step(1);
    expect_modes("R5 init once idle", 1'b1, 1'b0);

    ctl_write(3'b110);
    step(1);
    expect_modes("R3 sleep with wake enabled", 1'b0, 1'b1);

    // R8: bus wake
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    expect_val("R8 wake irq raised", K_IRQ, 32'd1);
    expect_modes("R8 still asleep at irq", 1'b0, 1'b1);
    step(1);
    expect_val("R8 irq one cycle", K_IRQ, 32'd0);
    ticks(11, 1'b0);
    expect_modes("R8 normal after bus wake", 1'b0, 1'b0);

    ctl_write(3'b010);
    step(1);
    expect_modes("R3 normal to sleep", 1'b0, 1'b1);

    // R9: software wake raises no irq
    ctl_write(3'b000);
    expect_val("R9 no irq on software wake", K_IRQ, 32'd0);
    step(1);
    ticks(11, 1'b1);
    expect_modes("R9 normal after software wake", 1'b0, 1'b0);

    // R10: control write coincides with bus wake
    ctl_write(3'b110);
    step(1);
    expect_modes("R10 asleep before overlap", 1'b0, 1'b1);
    @(negedge clk); sof = 1'b1; ctl_we = 1'b1; ctl_wdata = 3'b100;
    @(negedge clk); sof = 1'b0; ctl_we = 1'b0;
    expect_val("R10 irq on coincident write", K_IRQ, 32'd1);
    step(1);
    expect_val("R10 irq single", K_IRQ, 32'd0);
    ticks(11, 1'b0);
    expect_modes("R10 normal after overlap", 1'b0, 1'b0);

    step(2);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule